// File: doc/BRIEF.md
# Store-Release Execute Unit

This unit executes one instruction word of the register store-release operation. Two addressing forms are accepted. The plain form stores to the base address unchanged. The pre-decrement form first lowers the base by the access size, stores to the lowered address, and then writes that address back to the base register. The unit reads the base and data operands through a 32-entry register-file read interface. A base index of 31 selects the stack pointer instead of a general register. The unit then issues one store request over a valid/ready handshake. Each request carries a release-ordering attribute, a byte count and a tag-check flag for the memory system downstream.

Words that match neither form are rejected through a one-cycle undefined pulse. A stack-pointer base that is not 16-byte aligned is rejected through a one-cycle alignment-fault pulse. In the pre-decrement form, the base and data register numbers can name the same general register. A static configuration input decides how that collision is handled.

Top module: `srel_exec_unit`

## Requirements
- R1: Bit 30 of the word picks the access width: 0 gives a 4-byte store (`stBytes`=4) and 1 gives an 8-byte store (`stBytes`=8).
- R2: The plain form (bit 31=1, bits 29:21=001000100, bits 20:16=11111, bit 15=1, bits 14:10=11111) stores to the base value with no offset and causes no register update.
- R3: The pre-decrement form (bit 31=1, bits 29:24=011001, bits 23:22=10, bits 21:10=000000000010) stores to the base minus 4 or 8, then writes that same address back to the base register.
- R4: Base index 31 (bits 9:5) reads `spIn` instead of the register file, and its writeback goes out on `spWrEn`/`spWrData` instead of `rfWrEn`.
- R5: With base index 31 and `spIn[3:0]` not zero, `alignFault` pulses for one cycle and neither a store nor a writeback follows.
- R6: A word that matches neither form pulses `undefOut` for one cycle, one cycle after acceptance, with no store and no writeback.
- R7: In the pre-decrement form with data index equal to base index and not 31, `overlapMode` decides the outcome: 0 stores the original data value, 1 stores zero, 2 is treated as undefined (R6), 3 does nothing at all.
- R8: A 4-byte store carries the low 32 bits of the data register zero-extended; data index 31 stores zero.
- R9: `stRelease` is 1 on every request; `stTagChk` is 1 for the pre-decrement form and, for the plain form, 1 only when the base index is not 31.
- R10: `stValid` stays high with stable address, data and byte count until `stReady`; `instReady` is low while an instruction is in progress; a writeback is asserted for exactly the one cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word offered |
| instWord | input | 32 | Instruction word |
| instReady | output | 1 | Unit idle, word taken when valid |
| overlapMode | input | 2 | Static choice for base/data register collision |
| rfRdIdxBase | output | 5 | Register-file read index for the base |
| rfRdBase | input | XLEN | Base register value (combinational read) |
| rfRdIdxData | output | 5 | Register-file read index for the data |
| rfRdData | input | XLEN | Data register value (combinational read) |
| spIn | input | XLEN | Current stack pointer |
| stValid | output | 1 | Store request valid |
| stReady | input | 1 | Store request taken |
| stAddr | output | XLEN | Store address |
| stData | output | XLEN | Store data, zero-extended for 4-byte stores |
| stBytes | output | 4 | Byte count, 4 or 8 |
| stRelease | output | 1 | Release-ordering attribute |
| stTagChk | output | 1 | Tag check requested |
| rfWrEn | output | 1 | General register writeback strobe |
| rfWrIdx | output | 5 | Writeback register index |
| rfWrData | output | XLEN | Writeback value |
| spWrEn | output | 1 | Stack pointer writeback strobe |
| spWrData | output | XLEN | New stack pointer value |
| undefOut | output | 1 | Undefined-instruction pulse |
| alignFault | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The assertions assume that `overlapMode` does not change while an instruction is in flight. They also assume that the register-file read data settles in the same cycle as the read index, and that `stReady` is a clean level sampled only while `stValid` is high. The bench holds `overlapMode` steady across each instruction and answers reads from a combinational model array. It raises `stReady` only after it has seen the request, sometimes after a stall of a few cycles. Each word is offered for a single cycle while `instReady` is high.

// File: rtl/srel_pkg.sv
package srel_pkg;
  localparam int REG_IDX_W = 5;
  localparam logic [REG_IDX_W-1:0] SP_IDX = 5'd31;
  localparam int NARROW_W = 32;
  localparam int BYTES_W = 4;

  typedef enum logic [1:0] {
    OVL_KEEP  = 2'd0,
    OVL_ZERO  = 2'd1,
    OVL_UNDEF = 2'd2,
    OVL_SKIP  = 2'd3
  } overlap_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WB   = 2'd2
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic wbFire;
  } ctrl_strobe_t;

  // datapath -> control decode status
  typedef struct packed {
    logic undef;
    logic skip;
    logic misalign;
    logic wback;
  } dec_status_t;
endpackage

// File: rtl/srel_datapath.sv
module srel_datapath
  import srel_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [31:0]          instWord,
  input  logic [1:0]           overlapMode,
  output logic [REG_IDX_W-1:0] rfRdIdxBase,
  input  logic [XLEN-1:0]      rfRdBase,
  output logic [REG_IDX_W-1:0] rfRdIdxData,
  input  logic [XLEN-1:0]      rfRdData,
  input  logic [XLEN-1:0]      spIn,
  input  ctrl_strobe_t         strobe,
  output dec_status_t          status,
  output logic [XLEN-1:0]      stAddr,
  output logic [XLEN-1:0]      stData,
  output logic [BYTES_W-1:0]   stBytes,
  output logic                 stTagChk,
  output logic                 rfWrEn,
  output logic [REG_IDX_W-1:0] rfWrIdx,
  output logic [XLEN-1:0]      rfWrData,
  output logic                 spWrEn,
  output logic [XLEN-1:0]      spWrData
);
  logic [REG_IDX_W-1:0] rnIdx, rtIdx;
  logic isWide, plainHit, preHit, baseSp, collide;
  overlap_e ovl;
  logic [XLEN-1:0] baseVal, offsetVal, effAddr, rawData, storeData;
  logic [BYTES_W-1:0] accBytes;
  logic tagNow;

  logic [XLEN-1:0] heldAddr, heldData;
  logic [BYTES_W-1:0] heldBytes;
  logic heldTag, heldBaseSp;
  logic [REG_IDX_W-1:0] heldRn;

  assign rnIdx = instWord[9:5];
  assign rtIdx = instWord[4:0];
  assign isWide = instWord[30];
  assign rfRdIdxBase = rnIdx;
  assign rfRdIdxData = rtIdx;

  // fixed-pattern decode of the two forms
  assign plainHit = instWord[31] && (instWord[29:21] == 9'b001000100)
                 && (instWord[20:16] == 5'b11111) && instWord[15]
                 && (instWord[14:10] == 5'b11111);
  assign preHit = instWord[31] && (instWord[29:24] == 6'b011001)
               && (instWord[23:22] == 2'b10)
               && (instWord[21:10] == 12'b000000000010);

  assign baseSp  = (rnIdx == SP_IDX);
  assign collide = preHit && (rnIdx == rtIdx) && !baseSp;
  assign ovl     = overlap_e'(overlapMode);

  always_comb begin
    status.undef    = !(plainHit || preHit) || (collide && ovl == OVL_UNDEF);
    status.skip     = collide && (ovl == OVL_SKIP);
    status.misalign = baseSp && (|spIn[SP_ALIGN_BITS-1:0]);
    status.wback    = preHit;
  end

  // address and data formation
  assign accBytes  = isWide ? BYTES_W'(8) : BYTES_W'(4);
  assign baseVal   = baseSp ? spIn : rfRdBase;
  assign offsetVal = preHit ? XLEN'(accBytes) : '0;
  assign effAddr   = baseVal - offsetVal;
  assign rawData   = (rtIdx == SP_IDX) ? '0 : rfRdData;
  assign tagNow    = preHit || !baseSp;

  always_comb begin
    if (collide && ovl == OVL_ZERO) storeData = '0;
    else if (isWide)                storeData = rawData;
    else                            storeData = XLEN'(rawData[NARROW_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr   <= '0;
      heldData   <= '0;
      heldBytes  <= '0;
      heldTag    <= 1'b0;
      heldBaseSp <= 1'b0;
      heldRn     <= '0;
    end else if (strobe.capture) begin
      heldAddr   <= effAddr;
      heldData   <= storeData;
      heldBytes  <= accBytes;
      heldTag    <= tagNow;
      heldBaseSp <= baseSp;
      heldRn     <= rnIdx;
    end
  end

  assign stAddr   = heldAddr;
  assign stData   = heldData;
  assign stBytes  = heldBytes;
  assign stTagChk = heldTag;
  assign rfWrEn   = strobe.wbFire && !heldBaseSp;
  assign rfWrIdx  = heldRn;
  assign rfWrData = heldAddr;
  assign spWrEn   = strobe.wbFire && heldBaseSp;
  assign spWrData = heldAddr;
endmodule

// File: rtl/srel_control.sv
module srel_control
  import srel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instValid,
  output logic         instReady,
  input  dec_status_t  status,
  input  logic         stReady,
  output logic         stValid,
  output ctrl_strobe_t strobe,
  output logic         undefOut,
  output logic         alignFault
);
  phase_e phase, phaseNext;
  logic accept, goStore, needWb;

  assign instReady = (phase == ST_IDLE);
  assign accept    = instValid && instReady;
  assign goStore   = accept && !status.undef && !status.skip && !status.misalign;
  assign stValid   = (phase == ST_REQ);

  always_comb begin
    strobe.capture = goStore;
    strobe.wbFire  = (phase == ST_WB);
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      ST_IDLE: if (goStore) phaseNext = ST_REQ;
      ST_REQ:  if (stReady) phaseNext = needWb ? ST_WB : ST_IDLE;
      ST_WB:   phaseNext = ST_IDLE;
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= ST_IDLE;
      needWb     <= 1'b0;
      undefOut   <= 1'b0;
      alignFault <= 1'b0;
    end else begin
      phase      <= phaseNext;
      undefOut   <= accept && status.undef;
      alignFault <= accept && !status.undef && !status.skip && status.misalign;
      if (goStore) needWb <= status.wback;
    end
  end
endmodule

// File: rtl/srel_exec_unit.sv
module srel_exec_unit
  import srel_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic [31:0]          instWord,
  output logic                 instReady,
  input  logic [1:0]           overlapMode,
  output logic [REG_IDX_W-1:0] rfRdIdxBase,
  input  logic [XLEN-1:0]      rfRdBase,
  output logic [REG_IDX_W-1:0] rfRdIdxData,
  input  logic [XLEN-1:0]      rfRdData,
  input  logic [XLEN-1:0]      spIn,
  output logic                 stValid,
  input  logic                 stReady,
  output logic [XLEN-1:0]      stAddr,
  output logic [XLEN-1:0]      stData,
  output logic [BYTES_W-1:0]   stBytes,
  output logic                 stRelease,
  output logic                 stTagChk,
  output logic                 rfWrEn,
  output logic [REG_IDX_W-1:0] rfWrIdx,
  output logic [XLEN-1:0]      rfWrData,
  output logic                 spWrEn,
  output logic [XLEN-1:0]      spWrData,
  output logic                 undefOut,
  output logic                 alignFault
);
  ctrl_strobe_t strobe;
  dec_status_t  status;

  srel_control u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .status(status), .stReady(stReady), .stValid(stValid), .strobe(strobe),
    .undefOut(undefOut), .alignFault(alignFault)
  );

  srel_datapath #(.XLEN(XLEN), .SP_ALIGN_BITS(SP_ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .instWord(instWord), .overlapMode(overlapMode),
    .rfRdIdxBase(rfRdIdxBase), .rfRdBase(rfRdBase),
    .rfRdIdxData(rfRdIdxData), .rfRdData(rfRdData), .spIn(spIn),
    .strobe(strobe), .status(status),
    .stAddr(stAddr), .stData(stData), .stBytes(stBytes), .stTagChk(stTagChk),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .spWrEn(spWrEn), .spWrData(spWrData)
  );

  assign stRelease = stValid;
endmodule

// File: rtl/srel_exec_checker.sv
module srel_exec_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            instReady,
  input logic            stValid,
  input logic            stReady,
  input logic [XLEN-1:0] stAddr,
  input logic [XLEN-1:0] stData,
  input logic [3:0]      stBytes,
  input logic            rfWrEn,
  input logic            spWrEn,
  input logic [XLEN-1:0] rfWrData,
  input logic [XLEN-1:0] spWrData,
  input logic            undefOut,
  input logic            alignFault
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid && !stReady |=> stValid && $stable(stAddr) && $stable(stData) && $stable(stBytes));

  // R10
  wb_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn || spWrEn) |-> $past(stValid && stReady));

  // R3
  wb_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> rfWrData == $past(stAddr));

  // R4
  sp_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |-> spWrData == $past(stAddr));

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rfWrEn, spWrEn}));

  // R1
  bytes_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid |-> (stBytes == 4'd4 || stBytes == 4'd8));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid |-> !instReady);

  // R6
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    undefOut |-> !stValid && !rfWrEn && !spWrEn && !alignFault);

  // R5
  align_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !stValid && !rfWrEn && !spWrEn);
endmodule

bind srel_exec_unit srel_exec_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_srel_exec_unit.sv
module test_srel_exec_unit;
  localparam int XLEN = 64;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic instReady;
  logic [1:0] overlapMode = 2'd0;
  logic [4:0] rfRdIdxBase, rfRdIdxData, rfWrIdx;
  logic [XLEN-1:0] rfRdBase, rfRdData, stAddr, stData, rfWrData, spWrData;
  logic [XLEN-1:0] spIn = 64'h1000;
  logic stValid, stReady = 1'b0, stRelease, stTagChk, rfWrEn, spWrEn, undefOut, alignFault;
  logic [3:0] stBytes;

  logic [XLEN-1:0] rf [32];
  assign rfRdBase = rf[rfRdIdxBase];
  assign rfRdData = rf[rfRdIdxData];

  int checks = 0;
  int failures = 0;
  bit done = 0;

  srel_exec_unit #(.XLEN(XLEN)) i_srel_exec_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] plainWord(bit wide, logic [4:0] rn, logic [4:0] rt);
    return {1'b1, wide, 9'b001000100, 5'b11111, 1'b1, 5'b11111, rn, rt};
  endfunction

  function automatic logic [31:0] preWord(bit wide, logic [4:0] rn, logic [4:0] rt);
    return {1'b1, wide, 6'b011001, 2'b10, 12'b000000000010, rn, rt};
  endfunction

  // Offer a word for one cycle; returns at the negedge after acceptance.
  task automatic offer(input logic [31:0] w);
    @(negedge clk);
    instWord = w;
    instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  // Complete a store that is already visible, checking fields and writeback.
  task automatic finishStore(input string req, input logic [63:0] eAddr, input logic [63:0] eData,
                             input int eBytes, input bit eTag, input int wbKind, input logic [4:0] wbIdx,
                             input int stall);
    chk(stValid === 1'b1, req, stValid, 1);
    chk(stAddr === eAddr, req, stAddr, eAddr);
    chk(stData === eData, req, stData, eData);
    chk(stBytes === 4'(eBytes), req, stBytes, eBytes);
    chk(stRelease === 1'b1, "R9 release", stRelease, 1);
    chk(stTagChk === eTag, "R9 tag", stTagChk, eTag);
    chk(instReady === 1'b0, "R10 busy", instReady, 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(stValid === 1'b1 && stAddr === eAddr && stData === eData, "R10 hold", stAddr, eAddr);
      chk(!rfWrEn && !spWrEn, "R10 no early wb", {rfWrEn, spWrEn}, 0);
    end
    stReady = 1'b1;
    @(negedge clk);
    stReady = 1'b0;
    // wbKind: 0 none, 1 general register, 2 stack pointer
    chk(rfWrEn === (wbKind == 1), "R10 rf wb strobe", rfWrEn, wbKind == 1);
    chk(spWrEn === (wbKind == 2), "R4 sp wb strobe", spWrEn, wbKind == 2);
    if (wbKind == 1) begin
      chk(rfWrIdx === wbIdx && rfWrData === eAddr, "R3 wb value", rfWrData, eAddr);
      rf[rfWrIdx] = rfWrData;
    end
    if (wbKind == 2) begin
      chk(spWrData === eAddr, "R4 sp value", spWrData, eAddr);
      spIn = spWrData;
    end
    chk(stValid === 1'b0, "R10 request dropped", stValid, 0);
    @(negedge clk);
    chk(!rfWrEn && !spWrEn && instReady, "R10 single wb cycle", {rfWrEn, spWrEn, instReady}, 1);
  endtask

  // Expect rejection: no store, no writeback, optional pulse.
  task automatic expectQuiet(input string req, input bit eUndef, input bit eAlign);
    chk(undefOut === eUndef, req, undefOut, eUndef);
    chk(alignFault === eAlign, req, alignFault, eAlign);
    chk(stValid === 1'b0 && instReady === 1'b1, req, {stValid, instReady}, 1);
    @(negedge clk);
    chk(!undefOut && !alignFault && !stValid && !rfWrEn && !spWrEn, {req, " one cycle"},
        {undefOut, alignFault, stValid, rfWrEn, spWrEn}, 0);
  endtask

  task automatic testReset();
    chk(instReady === 1'b1 && stValid === 1'b0, "R10 reset", {instReady, stValid}, 2'b10);
    chk(!undefOut && !alignFault && !rfWrEn && !spWrEn, "R6 reset pulses", undefOut, 0);
  endtask

  task automatic testPlain();
    offer(plainWord(1, 5'd3, 5'd5));   // R2 R1: 8-byte, no writeback
    finishStore("R2 plain wide", rf[3], rf[5], 8, 1, 0, 0, 0);
    offer(plainWord(0, 5'd4, 5'd6));   // R8: narrow store zero-extends
    finishStore("R8 plain narrow", rf[4], {32'h0, rf[6][31:0]}, 4, 1, 0, 0, 3);
  endtask

  task automatic testPre();
    logic [63:0] b;
    b = rf[7];
    offer(preWord(1, 5'd7, 5'd8));     // R3 wide pre-decrement
    finishStore("R3 pre wide", b - 64'd8, rf[8], 8, 1, 1, 5'd7, 2);
    chk(rf[7] === b - 64'd8, "R3 base updated", rf[7], b - 64'd8);
    b = rf[10];
    offer(preWord(0, 5'd10, 5'd11));   // R3 narrow pre-decrement
    finishStore("R3 pre narrow", b - 64'd4, {32'h0, rf[11][31:0]}, 4, 1, 1, 5'd10, 0);
  endtask

  task automatic testStackPointer();
    spIn = 64'h1000;
    offer(preWord(0, 5'd31, 5'd2));    // R4 pre via stack pointer
    finishStore("R4 sp pre", 64'hFFC, {32'h0, rf[2][31:0]}, 4, 1, 2, 0, 0);
    spIn = 64'h2000;
    offer(plainWord(1, 5'd31, 5'd2));  // R9 plain via stack pointer: no tag check
    finishStore("R9 sp plain tag", 64'h2000, rf[2], 8, 0, 0, 0, 1);
    spIn = 64'h2008;
    offer(plainWord(1, 5'd31, 5'd2));  // R5 misaligned stack pointer
    expectQuiet("R5 align fault", 0, 1);
    offer(preWord(1, 5'd31, 5'd2));
    expectQuiet("R5 align fault pre", 0, 1);
    chk(spIn === 64'h2008, "R5 sp unchanged", spIn, 64'h2008);
    spIn = 64'h1000;
  endtask

  task automatic testUndef();
    logic [31:0] w;
    w = plainWord(1, 5'd3, 5'd5);
    w[15] = 1'b0;
    offer(w);
    expectQuiet("R6 bad fixed bit", 1, 0);
    w = preWord(1, 5'd3, 5'd5);
    w[31] = 1'b0;
    offer(w);
    expectQuiet("R6 bad size", 1, 0);
    offer(32'h0);
    expectQuiet("R6 zero word", 1, 0);
  endtask

  task automatic testOverlap();
    logic [63:0] b;
    overlapMode = 2'd0;
    b = rf[9];
    offer(preWord(1, 5'd9, 5'd9));     // R7 keep original value
    finishStore("R7 keep", b - 64'd8, b, 8, 1, 1, 5'd9, 0);
    overlapMode = 2'd1;
    b = rf[9];
    offer(preWord(1, 5'd9, 5'd9));     // R7 zero data
    finishStore("R7 zero", b - 64'd8, 64'h0, 8, 1, 1, 5'd9, 0);
    overlapMode = 2'd2;
    offer(preWord(1, 5'd9, 5'd9));     // R7 undefined
    expectQuiet("R7 undef", 1, 0);
    overlapMode = 2'd3;
    b = rf[9];
    offer(preWord(1, 5'd9, 5'd9));     // R7 no operation
    expectQuiet("R7 skip", 0, 0);
    chk(rf[9] === b, "R7 skip base unchanged", rf[9], b);
    overlapMode = 2'd2;
    offer(plainWord(1, 5'd12, 5'd12)); // R7 collision only matters for pre form
    finishStore("R7 plain collide", rf[12], rf[12], 8, 1, 0, 0, 0);
    overlapMode = 2'd0;
  endtask

  task automatic testZeroReg();
    offer(plainWord(1, 5'd3, 5'd31));  // R8 data index 31 stores zero
    finishStore("R8 zero data", rf[3], 64'h0, 8, 1, 0, 0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = {32'hA5000000 + 32'(i * 17), 32'h10000000 * 32'(i % 7) + 32'(i * 256)};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testPre();
    testStackPointer();
    testUndef();
    testOverlap();
    testZeroReg();
    finishRun();
  end
endmodule